// File: doc/BRIEF.md
# E1 Frame Aligner

This block locks onto the basic frame structure of a serial E1 receive stream: frames of 32 timeslots of 8 bits (256 bits per frame). Bits enter one at a time on `rx_bit_i`, qualified by a one-cycle strobe `bit_en_i` that comes from the recovered line clock. The frame alignment word `0011011` is sent in timeslot 0 of every other frame. In the frames between, timeslot 0 carries a non-alignment word whose second bit is always 1.

Acquisition has three steps. First the aligner slides a 7-bit window along the stream until the window holds the alignment word. Next it checks the second bit of timeslot 0 in the following frame, which must be 1. Last it checks for the alignment word in the frame after that. Once all three steps pass, `sync_o` rises, and the timeslot, bit and frame-parity outputs report where the most recently received bit lies in the frame.

While in lock, the aligner keeps checking every alignment word. Each errored alignment word counts toward `err_toggle_o`, which flips once per group of errored words (16 by default). Software can therefore estimate the bit error rate as group × toggles / (7 × 4000 × seconds). A run of consecutive errored alignment words drops lock and restarts the search.

Top module: `e1_frame_aligner`

## Requirements
- R1: After reset, `sync_o`, `ts_o`, `bit_o`, `frame_par_o` and `err_toggle_o` are all 0.
- R2: While hunting, every strobed bit is appended to a 7-bit window, with the first-received bit oldest. A window equal to `0011011` marks the current bit as bit 7 of timeslot 0 in an alignment frame. This holds at any bit offset, and finding a candidate does not by itself raise `sync_o`.
- R3: After a candidate, bit 1 of timeslot 0 in the next frame (256 bits on from the candidate's timeslot-0 start) is checked. If it is 0, hunting resumes, and the search starts with the bit that follows.
- R4: If that bit is 1, the window is checked again at bit 7 of timeslot 0 in the frame after that. A match raises `sync_o` in the cycle after that bit's strobe; a mismatch returns to hunting.
- R5: While `sync_o` is 1, `ts_o` (0–31) and `bit_o` (0–7, where 0 is the first-received bit of a timeslot) give the position of the most recently received bit. `frame_par_o` is 0 in alignment frames and 1 in the others. The position advances by one bit per strobe and wraps from timeslot 31 bit 7 to timeslot 0 bit 0, at which point the parity flips. When `sync_o` is 1, the position outputs read timeslot 0, bit 7, parity 0 in the cycle it rises. When `sync_o` is 0, all three position outputs are 0.
- R6: A cycle with `bit_en_i` low changes no output and no internal state.
- R7: In lock, three consecutive errored alignment words drop `sync_o` in the cycle after the third word's last bit. A correct alignment word resets the run. Non-alignment word contents are ignored while in lock.
- R8: `err_toggle_o` flips on every 16th errored alignment word counted in lock. Alignment words seen outside lock are not counted, and the running count survives a loss of lock.
- R9: An alignment word with any single one of its 7 bits wrong counts as errored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en_i | input | 1 | Strobe: `rx_bit_i` carries a new line bit this cycle |
| rx_bit_i | input | 1 | Serial receive data |
| sync_o | output | 1 | Frame alignment held |
| ts_o | output | 5 | Timeslot of last received bit (0 when not in sync) |
| bit_o | output | 3 | Bit within timeslot of last received bit (0 when not in sync) |
| frame_par_o | output | 1 | 0 in alignment frames, 1 in others (0 when not in sync) |
| err_toggle_o | output | 1 | Flips once per group of errored alignment words |

## Verification
The bench builds the aligner with its default parameters: 32 timeslots, an error group of 16 and a loss threshold of 3. These are the values the line actually uses. With 256-bit frames, a full group of 16 errored words spaced by good ones fits in roughly 64 frames. That keeps the first toggle of `err_toggle_o`, the later loss of lock and two reacquisitions (one that fails on the non-alignment bit and one that fails on the confirming word) all within a short run. Strobe gaps are inserted regularly, so the hold behaviour is exercised throughout rather than only at one point.

// File: rtl/e1fa_pkg.sv
package e1fa_pkg;

    // Acquisition and tracking phases of the aligner.
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,   // sliding the 7-bit window
        ST_NFAS = 2'd1,   // waiting for bit 1 of the next timeslot 0
        ST_CONF = 2'd2,   // waiting for the confirming alignment word
        ST_LOCK = 2'd3    // aligned, monitoring every alignment word
    } fa_state_e;

    // Position of the most recently received bit inside the double frame.
    localparam int unsigned FAS_W      = 7;
    localparam logic [FAS_W-1:0] FAS_WORD = 7'b0011011;
    localparam int unsigned FAS_LAST   = 7;  // bit index of the last FAS bit
    localparam int unsigned NFAS_CHECK = 1;  // bit index that must read 1

endpackage

// File: rtl/e1fa_window.sv
module e1fa_window
    import e1fa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en_i,
    input  logic rx_bit_i,
    output logic match_o
);

    typedef struct packed {
        logic [FAS_W-1:0] win;
    } win_regs_t;

    win_regs_t        r_q, r_d;
    logic [FAS_W-1:0] next_win;

    // The match is evaluated on the window that includes the bit
    // arriving this cycle, so the caller can act on the same strobe.
    always_comb begin
        r_d      = r_q;
        next_win = {r_q.win[FAS_W-2:0], rx_bit_i};
        if (bit_en_i) begin
            r_d.win = next_win;
        end
        match_o = (next_win == FAS_WORD);
    end

    // Reset to all ones: the word begins with two zeros, so no false
    // match can be assembled from reset contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.win <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assert_window_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en_i |=> $stable(r_q.win));

endmodule

// File: rtl/e1fa_position.sv
module e1fa_position #(
    parameter int unsigned TS_COUNT = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               bit_en_i,
    input  logic                               load_i,
    input  logic [$clog2(TS_COUNT*8)-1:0]      load_pos_i,
    output logic [$clog2(TS_COUNT*8)-1:0]      cur_pos_o,
    output logic                               cur_par_o,
    output logic [$clog2(TS_COUNT*8)-1:0]      pos_o,
    output logic                               par_o
);

    localparam int unsigned FRAME_BITS = TS_COUNT * 8;
    localparam int unsigned POS_W      = $clog2(FRAME_BITS);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             par;
    } pos_regs_t;

    pos_regs_t r_q, r_d;
    logic      at_wrap;

    // cur_* is the position the bit arriving this cycle will occupy.
    always_comb begin
        r_d       = r_q;
        at_wrap   = (r_q.pos == POS_LAST);
        cur_pos_o = at_wrap ? '0 : r_q.pos + 1'b1;
        cur_par_o = at_wrap ? ~r_q.par : r_q.par;
        if (load_i) begin
            r_d.pos = load_pos_i;
            r_d.par = 1'b0;
        end else if (bit_en_i) begin
            r_d.pos = cur_pos_o;
            r_d.par = cur_par_o;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pos_o = r_q.pos;
    assign par_o = r_q.par;

    assert_pos_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en_i && !load_i && r_q.pos != POS_LAST)
            |=> (r_q.pos == POS_W'($past(r_q.pos) + 1'b1)) && $stable(r_q.par));

    assert_pos_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en_i && !load_i && r_q.pos == POS_LAST)
            |=> (r_q.pos == '0) && (r_q.par != $past(r_q.par)));

endmodule

// File: rtl/e1fa_err_tally.sv
module e1fa_err_tally #(
    parameter int unsigned ERR_GROUP = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic err_i,
    output logic toggle_o
);

    localparam int unsigned CNT_W = (ERR_GROUP > 1) ? $clog2(ERR_GROUP) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ERR_GROUP - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tog;
    } tally_regs_t;

    tally_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (err_i) begin
            if (r_q.cnt == CNT_LAST) begin
                r_d.cnt = '0;
                r_d.tog = ~r_q.tog;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign toggle_o = r_q.tog;

    assert_toggle_needs_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !err_i |=> $stable(r_q.tog));

endmodule

// File: rtl/e1_frame_aligner.sv
module e1_frame_aligner
    import e1fa_pkg::*;
#(
    parameter int unsigned TS_COUNT   = 32,
    parameter int unsigned ERR_GROUP  = 16,
    parameter int unsigned LOSS_COUNT = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bit_en_i,
    input  logic                              rx_bit_i,
    output logic                              sync_o,
    output logic [$clog2(TS_COUNT)-1:0]       ts_o,
    output logic [2:0]                        bit_o,
    output logic                              frame_par_o,
    output logic                              err_toggle_o
);

    localparam int unsigned POS_W  = $clog2(TS_COUNT * 8);
    localparam int unsigned MISS_W = $clog2(LOSS_COUNT + 1);
    localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(LOSS_COUNT - 1);
    localparam logic [POS_W-1:0]  POS_FAS   = POS_W'(FAS_LAST);
    localparam logic [POS_W-1:0]  POS_NFAS  = POS_W'(NFAS_CHECK);

    typedef struct packed {
        fa_state_e         state;
        logic [MISS_W-1:0] miss;
    } fsm_regs_t;

    fsm_regs_t        r_q, r_d;
    logic             win_match;
    logic             load;
    logic             err_strobe;
    logic             fas_slot;
    logic             nfas_slot;
    logic [POS_W-1:0] cur_pos;
    logic             cur_par;
    logic [POS_W-1:0] pos_q;
    logic             par_q;

    e1fa_window u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en_i (bit_en_i),
        .rx_bit_i (rx_bit_i),
        .match_o  (win_match)
    );

    e1fa_position #(
        .TS_COUNT (TS_COUNT)
    ) u_position (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en_i   (bit_en_i),
        .load_i     (load),
        .load_pos_i (POS_FAS),
        .cur_pos_o  (cur_pos),
        .cur_par_o  (cur_par),
        .pos_o      (pos_q),
        .par_o      (par_q)
    );

    e1fa_err_tally #(
        .ERR_GROUP (ERR_GROUP)
    ) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .err_i    (err_strobe),
        .toggle_o (err_toggle_o)
    );

    always_comb begin
        r_d        = r_q;
        load       = 1'b0;
        err_strobe = 1'b0;
        fas_slot   = bit_en_i && !cur_par && (cur_pos == POS_FAS);
        nfas_slot  = bit_en_i &&  cur_par && (cur_pos == POS_NFAS);
        unique case (r_q.state)
            ST_HUNT: begin
                if (bit_en_i && win_match) begin
                    r_d.state = ST_NFAS;
                    load      = 1'b1;
                end
            end
            ST_NFAS: begin
                if (nfas_slot) begin
                    r_d.state = rx_bit_i ? ST_CONF : ST_HUNT;
                end
            end
            ST_CONF: begin
                if (fas_slot) begin
                    r_d.state = win_match ? ST_LOCK : ST_HUNT;
                    r_d.miss  = '0;
                end
            end
            ST_LOCK: begin
                if (fas_slot) begin
                    if (win_match) begin
                        r_d.miss = '0;
                    end else begin
                        err_strobe = 1'b1;
                        if (r_q.miss == MISS_LAST) begin
                            r_d.state = ST_HUNT;
                            r_d.miss  = '0;
                        end else begin
                            r_d.miss = r_q.miss + 1'b1;
                        end
                    end
                end
            end
            default: r_d.state = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_HUNT;
            r_q.miss  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sync_o      = (r_q.state == ST_LOCK);
    assign ts_o        = sync_o ? pos_q[POS_W-1:3] : '0;
    assign bit_o       = sync_o ? pos_q[2:0] : '0;
    assign frame_par_o = sync_o ? par_q : 1'b0;

    assert_lock_entry_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_o) |-> (pos_q == POS_FAS) && !par_q);

    assert_nfas_zero_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_NFAS && nfas_slot && !rx_bit_i) |=> (r_q.state == ST_HUNT));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en_i |=> $stable(pos_q) && $stable(par_q) && $stable(r_q.state)
                      && $stable(err_toggle_o));

    assert_loss_on_bad_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_o) |-> $past(fas_slot && !win_match));

    assert_count_only_in_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err_toggle_o) |-> $past(r_q.state == ST_LOCK));

endmodule

// File: tb/e1_frame_aligner_tb.sv
`timescale 1ns/1ps
module e1_frame_aligner_tb_top;

    localparam int FRAME_BITS = 256;
    localparam logic [6:0] FAS = 7'b0011011;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       rx_bit = 1'b1;
    logic       sync_o;
    logic [4:0] ts_o;
    logic [2:0] bit_o;
    logic       frame_par_o;
    logic       err_toggle_o;

    always #2.5 clk = ~clk;

    e1_frame_aligner dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_en_i     (bit_en),
        .rx_bit_i     (rx_bit),
        .sync_o       (sync_o),
        .ts_o         (ts_o),
        .bit_o        (bit_o),
        .frame_par_o  (frame_par_o),
        .err_toggle_o (err_toggle_o)
    );

    int tests = 0;
    int fails = 0;
    int nbits = 0;
    bit cmp_en = 1'b0;
    bit finished = 1'b0;

    // Behavioural reference model state.
    int         m_st = 0;     // 0 hunt, 1 await check bit, 2 await confirm, 3 locked
    int         m_pos = 0;
    bit         m_par = 1'b0;
    logic [6:0] m_win = 7'h7f;
    int         m_miss = 0;
    int         m_errs = 0;
    bit         m_err = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void model_step(input logic b);
        bit wrap;
        wrap  = (m_pos == FRAME_BITS - 1);
        m_pos = wrap ? 0 : m_pos + 1;
        m_par = wrap ? !m_par : m_par;
        m_win = {m_win[5:0], b};
        case (m_st)
            0: if (m_win == FAS) begin m_st = 1; m_pos = 7; m_par = 1'b0; end
            1: if (m_par && m_pos == 1) m_st = b ? 2 : 0;
            2: if (!m_par && m_pos == 7) m_st = (m_win == FAS) ? 3 : 0;
            3: if (!m_par && m_pos == 7) begin
                   if (m_win == FAS) m_miss = 0;
                   else begin
                       m_miss++;
                       m_errs++;
                       if (m_errs % 16 == 0) m_err = !m_err;
                       if (m_miss == 3) begin m_st = 0; m_miss = 0; end
                   end
               end
            default: m_st = 0;
        endcase
    endfunction

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (cmp_en) begin
            bit s;
            s = (m_st == 3);
            check(sync_o == s, "R4 sync vs model", sync_o, s);
            check(ts_o == (s ? m_pos / 8 : 0), "R5 ts vs model", ts_o, s ? m_pos / 8 : 0);
            check(bit_o == (s ? m_pos % 8 : 0), "R5 bit vs model", bit_o, s ? m_pos % 8 : 0);
            check(frame_par_o == (s ? m_par : 1'b0), "R5 parity vs model", frame_par_o,
                  s ? m_par : 0);
            check(err_toggle_o == m_err, "R8 toggle vs model", err_toggle_o, m_err);
        end
    end

    task automatic tick_bit(input logic b);
        rx_bit = b;
        bit_en = 1'b1;
        @(posedge clk);
        model_step(b);
        @(negedge clk);
        bit_en = 1'b0;
        nbits++;
        if (nbits % 7 == 0) @(negedge clk);   // regular strobe gap (R6)
    endtask

    task automatic ones(input int n);
        for (int i = 0; i < n; i++) tick_bit(1'b1);
    endtask

    task automatic fas_head(input logic [6:0] flip);
        logic [6:0] w;
        w = FAS ^ flip;
        tick_bit(1'b1);
        for (int i = 6; i >= 0; i--) tick_bit(w[i]);
    endtask

    task automatic payload();
        ones(FRAME_BITS - 8);
    endtask

    task automatic fas_frame(input logic [6:0] flip);
        fas_head(flip);
        payload();
    endtask

    task automatic nfas_frame(input logic b1);
        tick_bit(1'b1);
        tick_bit(b1);
        ones(FRAME_BITS - 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [4:0] ts_hold;
        logic [2:0] bit_hold;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(sync_o == 1'b0, "R1 sync after reset", sync_o, 0);
        check(ts_o == 0 && bit_o == 0, "R1 position after reset", {ts_o, bit_o}, 0);
        check(frame_par_o == 1'b0, "R1 parity after reset", frame_par_o, 0);
        check(err_toggle_o == 1'b0, "R1 toggle after reset", err_toggle_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_en = 1'b1;

        // R2: odd offset, candidate alone does not lock
        ones(37);
        fas_frame(7'h00);
        check(sync_o == 1'b0, "R2 no lock on candidate", sync_o, 0);
        nfas_frame(1'b1);
        fas_head(7'h00);
        check(sync_o == 1'b1, "R4 lock on confirm", sync_o, 1);
        check(ts_o == 0 && bit_o == 7 && frame_par_o == 0, "R5 entry position",
              {ts_o, bit_o, frame_par_o}, 14);
        ones(20);
        ts_hold  = ts_o;
        bit_hold = bit_o;
        repeat (6) @(negedge clk);
        check(ts_o == ts_hold && bit_o == bit_hold, "R6 idle hold", {ts_o, bit_o},
              {ts_hold, bit_hold});
        ones(FRAME_BITS - 28);

        // R7: check bit of 0 in lock is ignored
        nfas_frame(1'b0);
        check(sync_o == 1'b1, "R7 lock ignores non-alignment word", sync_o, 1);

        // R8/R9: 16 single-bit errored words separated by good ones
        for (int i = 0; i < 16; i++) begin
            fas_frame(7'h01 << (i % 7));
            nfas_frame(1'b1);
            if (i == 14) check(err_toggle_o == 1'b0, "R8 no toggle at 15", err_toggle_o, 0);
            fas_frame(7'h00);
            nfas_frame(1'b1);
        end
        check(err_toggle_o == 1'b1, "R9 single-bit errors toggle at 16", err_toggle_o, 1);
        check(sync_o == 1'b1, "R7 isolated errors keep lock", sync_o, 1);

        // R7: two misses then a good word keep lock
        fas_frame(7'h40); nfas_frame(1'b1);
        fas_frame(7'h01); nfas_frame(1'b1);
        fas_frame(7'h00); nfas_frame(1'b1);
        check(sync_o == 1'b1, "R7 run reset by good word", sync_o, 1);

        // R7: three consecutive misses drop lock
        fas_frame(7'h10); nfas_frame(1'b1);
        fas_frame(7'h02); nfas_frame(1'b1);
        fas_head(7'h7f);
        check(sync_o == 1'b0, "R7 loss after three misses", sync_o, 0);
        payload();
        nfas_frame(1'b1);

        // R8: bad words outside lock are not counted (count stays 21)
        fas_frame(7'h7f); nfas_frame(1'b1);
        fas_frame(7'h7f); nfas_frame(1'b1);
        check(err_toggle_o == 1'b1, "R8 no count outside lock", err_toggle_o, 1);

        // R3: failed check bit, then search resumes and catches next word
        fas_frame(7'h00);
        nfas_frame(1'b0);
        fas_frame(7'h00);
        check(sync_o == 1'b0, "R3 zero check bit aborts", sync_o, 0);
        nfas_frame(1'b1);
        fas_head(7'h00);
        check(sync_o == 1'b1, "R3 search resumed and locked", sync_o, 1);
        payload();
        nfas_frame(1'b1);

        // R4: failed confirming word
        fas_frame(7'h01); nfas_frame(1'b1);
        fas_frame(7'h01); nfas_frame(1'b1);
        fas_frame(7'h01); nfas_frame(1'b1);
        check(sync_o == 1'b0, "R7 second loss", sync_o, 0);
        fas_frame(7'h00);
        nfas_frame(1'b1);
        fas_head(7'h08);
        check(sync_o == 1'b0, "R4 bad confirm keeps hunting", sync_o, 0);
        payload();
        nfas_frame(1'b1);
        fas_frame(7'h00);
        nfas_frame(1'b1);
        fas_head(7'h00);
        check(sync_o == 1'b1, "R4 relock after bad confirm", sync_o, 1);
        check(err_toggle_o == 1'b1, "R8 count persists over loss", err_toggle_o, 1);

        cmp_en   = 1'b0;
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule